// File: doc/BRIEF.md
# Rank-Aware Memory Request Selector

This block sits inside one memory controller. It keeps a small buffer of pending memory requests, each tagged with the issuing thread, the target bank and the target row. In every cycle it looks at the requests whose bank is ready and picks one to issue. The chosen request leaves the buffer at the next clock edge, and the row it names becomes the open row of its bank.

The choice follows a strict order. A request that has waited longer than a programmable limit beats every request that has not. Next, the request whose thread holds the better global rank wins. An external ranker supplies one rank per thread, and a lower value is better. Among equal ranks, a request that targets the currently open row of its bank wins. The final tie-breaker is age: the oldest request wins.

Beside the buffer, one counter per thread measures attained service. The counter grows for each cycle in which a bank is busy with work last issued for that thread. The ranker reads these counters at the end of a quantum and clears them with an acknowledge pulse.

Top module: `req_sel`

## Requirements
- R1: While rst_ni is low and right after reset, issue_valid_o is 0, enq_ready_o is 1, every service counter reads 0, and every bank's open row is 0.
- R2: The buffer holds NUM_ENT (16) requests. A request offered with enq_valid_i while enq_ready_o is 1 is stored in the lowest-numbered free slot at the clock edge. enq_ready_o is 0 exactly when all slots are occupied. An offer made while it is 0 is dropped. A stored request becomes eligible from the following cycle.
- R3: Only stored requests whose bank has bank_ready_i set are eligible. issue_valid_o is 1 in a cycle exactly when an eligible request exists. The issued request is removed from the buffer at that cycle's clock edge.
- R4: A request's age is the number of cycles from the cycle it was stored to the current cycle. A request whose age is strictly greater than starve_thresh_i is starved, and an eligible starved request is chosen ahead of every non-starved one.
- R5: Among requests of equal starvation status, the one whose thread has the lower rank value wins. The rank of thread t is rank_i[t*RANK_W +: RANK_W], and 0 is the best rank.
- R6: Among requests that also have equal rank, one whose row equals its bank's open row wins. At every issue, the issued bank's open row becomes the issued row.
- R7: Among requests equal on all the rules above, the oldest wins.
- R8: In each cycle, every bank that has issued at least once since reset and has bank_ready_i low adds 1 to the service counter of the thread of its last issued request. The counter of thread t appears at svc_cnt_o[t*SVC_W +: SVC_W].
- R9: A cycle with svc_ack_i high sets every service counter to 0 at its clock edge, and that cycle adds no increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Offer a new request |
| enq_thread_i | input | THR_W | Thread of the offered request |
| enq_bank_i | input | BANK_W | Bank of the offered request |
| enq_row_i | input | ROW_W | Row of the offered request |
| enq_ready_o | output | 1 | A free slot exists |
| rank_i | input | NUM_THR*RANK_W | Per-thread rank, lower is better |
| starve_thresh_i | input | TS_W | Age limit beyond which a request is starved |
| bank_ready_i | input | NUM_BANK | Bank can accept a request |
| issue_valid_o | output | 1 | A request is issued this cycle |
| issue_slot_o | output | SLOT_W | Buffer slot of the issued request |
| issue_thread_o | output | THR_W | Thread of the issued request |
| issue_bank_o | output | BANK_W | Bank of the issued request |
| issue_row_o | output | ROW_W | Row of the issued request |
| svc_ack_i | input | 1 | Ranker has taken the counters, so clear them |
| svc_cnt_o | output | NUM_THR*SVC_W | Per-thread attained service |

## Verification
The assertions assume that enq_thread_i and enq_bank_i name an existing thread and bank. They also assume that no request waits 2^TS_W cycles or more, so the age subtraction never wraps. The stimulus only produces legal thread and bank numbers. Runs stay a few thousand cycles long, and the starvation limit stays far below the wrap point. Offers made while the buffer is full are allowed on purpose, so that the dropping rule is exercised. The acknowledge is driven as a single-cycle pulse at arbitrary points, including cycles in which banks are busy.

// File: rtl/req_sel_pkg.sv
package req_sel_pkg;
  localparam int DEF_NUM_ENT  = 16;
  localparam int DEF_NUM_BANK = 4;
  localparam int DEF_NUM_THR  = 4;
  localparam int DEF_ROW_W    = 8;
  localparam int DEF_TS_W     = 16;
  localparam int DEF_RANK_W   = 2;
  localparam int DEF_SVC_W    = 16;
endpackage

// File: rtl/req_sel_pick.sv
module req_sel_pick #(
  parameter int N     = 16,
  parameter int KEY_W = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       elig_i,
  input  logic [N*KEY_W-1:0] key_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [KEY_W-1:0] best;

  // strict compare keeps the lowest index on an exact tie
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!found_o || key_i[i*KEY_W +: KEY_W] > best)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        best    = key_i[i*KEY_W +: KEY_W];
      end
    end
  end
endmodule

// File: rtl/req_sel_svc.sv
module req_sel_svc #(
  parameter int NUM_THR  = 4,
  parameter int NUM_BANK = 4,
  parameter int SVC_W    = 16,
  localparam int THR_W = $clog2(NUM_THR),
  localparam int INC_W = $clog2(NUM_BANK + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ack_i,
  input  logic [NUM_BANK-1:0]       busy_i,
  input  logic [NUM_BANK-1:0]       own_vld_i,
  input  logic [NUM_BANK*THR_W-1:0] own_thr_i,
  output logic [NUM_THR*SVC_W-1:0]  cnt_o
);
  logic [INC_W-1:0] inc   [NUM_THR];
  logic [SVC_W-1:0] cnt_q [NUM_THR];

  always_comb begin
    for (int t = 0; t < NUM_THR; t++) begin
      inc[t] = '0;
      for (int b = 0; b < NUM_BANK; b++) begin
        if (busy_i[b] && own_vld_i[b] && own_thr_i[b*THR_W +: THR_W] == THR_W'(t))
          inc[t] = inc[t] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < NUM_THR; t++) cnt_q[t] <= '0;
    end else begin
      for (int t = 0; t < NUM_THR; t++)
        cnt_q[t] <= ack_i ? '0 : cnt_q[t] + SVC_W'(inc[t]);
    end
  end

  for (genvar g = 0; g < NUM_THR; g++) begin : g_out
    assign cnt_o[g*SVC_W +: SVC_W] = cnt_q[g];
  end

  p_ack_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (cnt_o == '0));
endmodule

// File: rtl/req_sel.sv
module req_sel
  import req_sel_pkg::*;
#(
  parameter int NUM_ENT  = DEF_NUM_ENT,
  parameter int NUM_BANK = DEF_NUM_BANK,
  parameter int NUM_THR  = DEF_NUM_THR,
  parameter int ROW_W    = DEF_ROW_W,
  parameter int TS_W     = DEF_TS_W,
  parameter int RANK_W   = DEF_RANK_W,
  parameter int SVC_W    = DEF_SVC_W,
  localparam int THR_W  = $clog2(NUM_THR),
  localparam int BANK_W = $clog2(NUM_BANK),
  localparam int SLOT_W = $clog2(NUM_ENT)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       enq_valid_i,
  input  logic [THR_W-1:0]           enq_thread_i,
  input  logic [BANK_W-1:0]          enq_bank_i,
  input  logic [ROW_W-1:0]           enq_row_i,
  output logic                       enq_ready_o,
  input  logic [NUM_THR*RANK_W-1:0]  rank_i,
  input  logic [TS_W-1:0]            starve_thresh_i,
  input  logic [NUM_BANK-1:0]        bank_ready_i,
  output logic                       issue_valid_o,
  output logic [SLOT_W-1:0]          issue_slot_o,
  output logic [THR_W-1:0]           issue_thread_o,
  output logic [BANK_W-1:0]          issue_bank_o,
  output logic [ROW_W-1:0]           issue_row_o,
  input  logic                       svc_ack_i,
  output logic [NUM_THR*SVC_W-1:0]   svc_cnt_o
);
  localparam int KEY_W = 1 + RANK_W + 1 + TS_W;

  logic [NUM_ENT-1:0] vld_q;
  logic [THR_W-1:0]   thr_q  [NUM_ENT];
  logic [BANK_W-1:0]  bank_q [NUM_ENT];
  logic [ROW_W-1:0]   row_q  [NUM_ENT];
  logic [TS_W-1:0]    ts_q   [NUM_ENT];
  logic [TS_W-1:0]    now_q;

  logic [ROW_W-1:0]          open_row_q [NUM_BANK];
  logic [NUM_BANK-1:0]       own_vld_q;
  logic [NUM_BANK*THR_W-1:0] own_thr_q;

  logic [NUM_ENT-1:0]       elig, starved;
  logic [NUM_ENT*KEY_W-1:0] key_flat;
  logic                     sel_found;
  logic [SLOT_W-1:0]        sel_idx;
  logic [SLOT_W-1:0]        free_idx;
  logic                     enq_fire;

  // priority key: starved, better rank, row hit, age (wider is older)
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic [TS_W-1:0]   age;
    logic [RANK_W-1:0] rk;
    logic              hit;
    assign age        = now_q - ts_q[g];
    assign rk         = rank_i[thr_q[g]*RANK_W +: RANK_W];
    assign hit        = (row_q[g] == open_row_q[bank_q[g]]);
    assign starved[g] = (age > starve_thresh_i);
    assign elig[g]    = vld_q[g] && bank_ready_i[bank_q[g]];
    assign key_flat[g*KEY_W +: KEY_W] = {starved[g], ~rk, hit, age};
  end

  req_sel_pick #(.N(NUM_ENT), .KEY_W(KEY_W)) u_pick (
    .elig_i  (elig),
    .key_i   (key_flat),
    .found_o (sel_found),
    .idx_o   (sel_idx)
  );

  always_comb begin
    free_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (!vld_q[i]) free_idx = SLOT_W'(i);
  end

  assign enq_ready_o    = ~&vld_q;
  assign enq_fire       = enq_valid_i && enq_ready_o;
  assign issue_valid_o  = sel_found;
  assign issue_slot_o   = sel_idx;
  assign issue_thread_o = thr_q[sel_idx];
  assign issue_bank_o   = bank_q[sel_idx];
  assign issue_row_o    = row_q[sel_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q     <= '0;
      now_q     <= '0;
      own_vld_q <= '0;
      own_thr_q <= '0;
      for (int i = 0; i < NUM_ENT; i++) begin
        thr_q[i]  <= '0;
        bank_q[i] <= '0;
        row_q[i]  <= '0;
        ts_q[i]   <= '0;
      end
      for (int b = 0; b < NUM_BANK; b++) open_row_q[b] <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      if (sel_found) begin
        vld_q[sel_idx]                          <= 1'b0;
        open_row_q[bank_q[sel_idx]]             <= row_q[sel_idx];
        own_vld_q[bank_q[sel_idx]]              <= 1'b1;
        own_thr_q[bank_q[sel_idx]*THR_W +: THR_W] <= thr_q[sel_idx];
      end
      if (enq_fire) begin
        vld_q[free_idx]  <= 1'b1;
        thr_q[free_idx]  <= enq_thread_i;
        bank_q[free_idx] <= enq_bank_i;
        row_q[free_idx]  <= enq_row_i;
        ts_q[free_idx]   <= now_q;
      end
    end
  end

  req_sel_svc #(.NUM_THR(NUM_THR), .NUM_BANK(NUM_BANK), .SVC_W(SVC_W)) u_svc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_i     (svc_ack_i),
    .busy_i    (~bank_ready_i),
    .own_vld_i (own_vld_q),
    .own_thr_i (own_thr_q),
    .cnt_o     (svc_cnt_o)
  );

  p_issue_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> bank_ready_i[issue_bank_o]);
  p_dequeue_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |=> !vld_q[$past(issue_slot_o)]);
  p_enq_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_fire |=> vld_q[$past(free_idx)]);
  p_open_row_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |=> open_row_q[$past(issue_bank_o)] == $past(issue_row_o));
  p_starve_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(elig & starved)) |-> (issue_valid_o && starved[issue_slot_o]));
endmodule

// File: tb/req_sel_tb.sv
module req_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 16, NB = 4, NT = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic enq_valid = 1'b0;
  logic [1:0] enq_thread = '0, enq_bank = '0;
  logic [7:0] enq_row = '0;
  logic enq_ready;
  logic [7:0] rank = '0;
  logic [15:0] thresh = 16'd5000;
  logic [3:0] bank_ready = '0;
  logic issue_valid;
  logic [3:0] issue_slot;
  logic [1:0] issue_thread, issue_bank;
  logic [7:0] issue_row;
  logic svc_ack = 1'b0;
  logic [63:0] svc_cnt;

  int checks = 0, failures = 0;
  bit done = 0;

  int m_vld[NE], m_thr[NE], m_bank[NE], m_row[NE], m_ts[NE];
  int m_open[NB], m_own_v[NB], m_own[NB], m_svc[NT];
  int m_now;

  always #(CLK_PERIOD/2) clk = ~clk;

  req_sel u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .enq_valid_i(enq_valid), .enq_thread_i(enq_thread), .enq_bank_i(enq_bank),
    .enq_row_i(enq_row), .enq_ready_o(enq_ready),
    .rank_i(rank), .starve_thresh_i(thresh), .bank_ready_i(bank_ready),
    .issue_valid_o(issue_valid), .issue_slot_o(issue_slot),
    .issue_thread_o(issue_thread), .issue_bank_o(issue_bank), .issue_row_o(issue_row),
    .svc_ack_i(svc_ack), .svc_cnt_o(svc_cnt)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int rk_of(input int t);
    return int'(rank[t*2 +: 2]);
  endfunction

  // returns 1 when entry a beats entry b
  function automatic bit beats(input int a, input int b);
    int aa, ab;
    bit sa, sb, ha, hb;
    aa = (m_now - m_ts[a]) & 16'hFFFF;
    ab = (m_now - m_ts[b]) & 16'hFFFF;
    sa = aa > int'(thresh);
    sb = ab > int'(thresh);
    if (sa != sb) return sa;
    if (rk_of(m_thr[a]) != rk_of(m_thr[b])) return rk_of(m_thr[a]) < rk_of(m_thr[b]);
    ha = m_row[a] == m_open[m_bank[a]];
    hb = m_row[b] == m_open[m_bank[b]];
    if (ha != hb) return ha;
    return aa > ab;
  endfunction

  task automatic step(input string tag);
    int win, cnt, slot;
    #1;
    win = -1;
    cnt = 0;
    for (int i = 0; i < NE; i++) begin
      if (m_vld[i] != 0) cnt++;
      if (m_vld[i] != 0 && bank_ready[m_bank[i]])
        if (win < 0 || beats(i, win)) win = i;
    end
    check(enq_ready == (cnt < NE), tag, "enq_ready", int'(enq_ready), int'(cnt < NE));
    check(issue_valid == (win >= 0), tag, "issue_valid", int'(issue_valid), int'(win >= 0));
    if (win >= 0 && issue_valid) begin
      check(int'(issue_slot) == win, tag, "issue_slot", int'(issue_slot), win);
      check(int'(issue_thread) == m_thr[win], tag, "issue_thread", int'(issue_thread), m_thr[win]);
      check(int'(issue_bank) == m_bank[win], tag, "issue_bank", int'(issue_bank), m_bank[win]);
      check(int'(issue_row) == m_row[win], tag, "issue_row", int'(issue_row), m_row[win]);
    end
    for (int t = 0; t < NT; t++)
      check(int'(svc_cnt[t*16 +: 16]) == m_svc[t], tag, "svc_cnt",
            int'(svc_cnt[t*16 +: 16]), m_svc[t]);
    // model update for this clock edge
    for (int t = 0; t < NT; t++) if (svc_ack) m_svc[t] = 0;
    if (!svc_ack)
      for (int b = 0; b < NB; b++)
        if (!bank_ready[b] && m_own_v[b] != 0) m_svc[m_own[b]] = (m_svc[m_own[b]] + 1) & 16'hFFFF;
    slot = -1;
    for (int i = NE - 1; i >= 0; i--) if (m_vld[i] == 0) slot = i;
    if (win >= 0) begin
      m_vld[win] = 0;
      m_open[m_bank[win]] = m_row[win];
      m_own[m_bank[win]] = m_thr[win];
      m_own_v[m_bank[win]] = 1;
    end
    if (enq_valid && slot >= 0) begin
      m_vld[slot] = 1;
      m_thr[slot] = int'(enq_thread);
      m_bank[slot] = int'(enq_bank);
      m_row[slot] = int'(enq_row);
      m_ts[slot] = m_now;
    end
    m_now++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic offer(input int t, input int b, input int r);
    enq_valid = 1'b1;
    enq_thread = 2'(t);
    enq_bank = 2'(b);
    enq_row = 8'(r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_vld[i] = 0; m_thr[i] = 0; m_bank[i] = 0; m_row[i] = 0; m_ts[i] = 0;
    end
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 0; m_own_v[b] = 0; m_own[b] = 0;
    end
    for (int t = 0; t < NT; t++) m_svc[t] = 0;
    m_now = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(issue_valid == 1'b0, "R1", "issue_valid in reset", int'(issue_valid), 0);
    check(enq_ready == 1'b1, "R1", "enq_ready in reset", int'(enq_ready), 1);
    check(svc_cnt == '0, "R1", "svc_cnt in reset", int'(svc_cnt[15:0]), 0);
    rst_ni = 1'b1;
    step("R1");

    // R2: fill all slots with no bank ready, then offer one more
    for (int i = 0; i < 17; i++) begin
      offer(i / 4 % 4, i % 4, i);
      step("R2");
    end
    enq_valid = 1'b0;
    check(enq_ready == 1'b0, "R2", "enq_ready when full", int'(enq_ready), 0);
    step("R2");

    // R3: nothing issues until a bank is ready
    repeat (3) step("R3");
    bank_ready = 4'b0100;
    step("R3");
    bank_ready = 4'b0000;
    repeat (2) step("R3");

    // R5: thread 3 best, thread 0 worst
    rank = {2'd0, 2'd1, 2'd2, 2'd3};
    bank_ready = 4'b0010;
    repeat (2) step("R5");
    bank_ready = 4'b0000;
    step("R5");

    // R6: equal ranks, younger request hitting the open row of bank 1
    rank = '0;
    offer(0, 1, m_open[1]);
    step("R6");
    enq_valid = 1'b0;
    bank_ready = 4'b0010;
    step("R6");
    bank_ready = 4'b0000;
    step("R6");

    // R7: equal ranks, no hits in bank 3, oldest first
    bank_ready = 4'b1000;
    repeat (2) step("R7");
    bank_ready = 4'b0000;

    // R4: fresh best-rank requests against starved older ones in bank 0
    rank = {2'd3, 2'd3, 2'd3, 2'd0};
    thresh = 16'd10;
    for (int i = 0; i < 3; i++) begin
      offer(0, 0, 100 + i);
      step("R4");
    end
    enq_valid = 1'b0;
    bank_ready = 4'b0001;
    repeat (3) step("R4");
    bank_ready = 4'b0000;
    thresh = 16'd5000;

    // R8: banks busy accumulate service
    repeat (5) step("R8");
    bank_ready = 4'b0101;
    repeat (2) step("R8");
    bank_ready = 4'b0000;
    repeat (3) step("R8");

    // R9: acknowledge clears
    svc_ack = 1'b1;
    step("R9");
    svc_ack = 1'b0;
    step("R9");
    check(int'(svc_cnt[15:0]) == m_svc[0], "R9", "svc_cnt after clear", int'(svc_cnt[15:0]), m_svc[0]);

    // mixed traffic against the reference model
    thresh = 16'd40;
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 3) != 0) offer($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 7));
      else enq_valid = 1'b0;
      bank_ready = 4'($urandom_range(0, 15));
      svc_ack = ($urandom_range(0, 63) == 0);
      if (c % 100 == 0) rank = 8'($urandom_range(0, 255));
      step((c % 2 == 0) ? "R7" : "R3");
    end
    enq_valid = 1'b0;
    svc_ack = 1'b0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule